// File: doc/BRIEF.md
# Configurable SPI Transfer Controller

This block is an 8-bit SPI shift engine that can act as bus master or as a selected slave. Software reaches it through a small register bus with five locations: a control byte, a status byte, a transmit holding buffer, a receive holding buffer and an SCLK divider. In master mode it produces SCLK, MOSI and an active-low select output. In slave mode it follows an external SCLK and an external select, and drives MISO through an output-enable line. All transfers use SPI mode 0: data is sampled on the rising SCLK edge, changed on the falling edge, and the MSB goes first.

The control byte sets four things. It chooses what starts a master transfer: a read of the receive buffer or a write of the transmit buffer. It decides what is shifted out when the transmit buffer is empty, and what happens to a word that arrives while the receive buffer is still full. It also sets whether an asserted select input is treated as a multimaster error while the block is master, and whether the slave is allowed to drive MISO at all. The MISO-disable option lets many slaves listen to a broadcast while only one of them answers. A DMA setting suppresses the block's own interrupt and instead exposes two buffer-state lines to an external DMA engine.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: The register map is as follows. Address 0 is control, with bits 1:0 the start mode, bit 2 send-zero, bit 3 get-more, bit 4 select-error enable, bit 5 MISO disable, bit 6 master and bit 7 enable. Address 1 is status, with bit 0 rx full, bit 1 tx empty, bit 2 overflow, bit 3 mode fault, bit 4 busy and bit 7 the synchronized select-input level. Address 2 is tx write, address 3 is rx read and address 4 is the divider. After reset, control reads 0x00 and status reads 0x82.
- R2: Start mode 01 starts a master transfer when the transmit buffer is written. The select output stays low for exactly 16*(DIV+1) clock cycles. A master running in loopback receives the word it sent. The interrupt is high while the transmit buffer is empty.
- R3: Start mode 00 starts a master transfer on each read of the receive buffer. The interrupt is high while the receive buffer is full.
- R4: When a transfer starts with the transmit buffer empty, the block sends the last word taken from the buffer if send-zero is 0, and sends all zeros if send-zero is 1.
- R5: A word that completes while the receive buffer is full sets the sticky overflow status bit in both policies. With get-more at 0 the old word is kept. With get-more at 1 the new word replaces it. Writing 1 to status bit 2 clears the overflow bit.
- R6: In master mode with select-error enable set, a low select input aborts the transfer, clears the master bit, raises the select output and sets the sticky mode-fault bit. Writing 1 to status bit 3 clears the mode-fault bit.
- R7: In master mode with select-error enable clear, the select input has no effect. Transfers complete and the master bit stays set.
- R8: In slave mode, a transfer runs only while the select input is low. The block shifts the transmit word out on MISO and captures MOSI into the receive buffer. Status bit 7 shows the select level.
- R9: When MISO disable is 1, the MISO output enable stays low even in a selected slave. When it is 0, a selected slave drives MISO.
- R10: In start mode 10, the interrupt stays low. A transmit write starts a transfer. The DMA lines report receive-full and transmit-empty.
- R11: In start mode 11, no transfer ever starts and the busy bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on rx read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| sclk_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| ss_out_n | output | 1 | Master select output, active low |
| miso_i | input | 1 | Master data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data-out driver enable |
| sclk_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave data in |
| ss_in_n | input | 1 | Select input, active low |
| irq | output | 1 | Interrupt, meaning set by start mode |
| dma_rx_full | output | 1 | Receive buffer full, DMA mode only |
| dma_tx_empty | output | 1 | Transmit buffer empty, DMA mode only |

## Verification
A bad bit counter or divider shows at the ports as a select-output low window that is not exactly 16*(DIV+1) cycles long, or as a loopback word that comes back rotated, and both appear within one transfer. Wrong buffer-flag state shows up at the interrupt and in the status byte one cycle after the bus access that caused it. A wrong underrun or overflow policy becomes visible on the first read of the receive buffer after the transfer concerned. A missed mode fault leaves the select output low and the master bit set a few cycles after the select input falls.

// File: rtl/spi_xfer_pkg.sv
// Shared types and address constants for the SPI transfer controller.
// Assumes an 8-bit control/status byte and a 3-bit register address.
package spi_xfer_pkg;

    // What starts a master transfer (and what the interrupt means)
    typedef enum logic [1:0] {
        IM_RX_READ  = 2'b00,
        IM_TX_WRITE = 2'b01,
        IM_DMA      = 2'b10,
        IM_RSVD     = 2'b11
    } init_mode_e;

    // Control byte, MSB first; imode occupies bits 1:0
    typedef struct packed {
        logic       enable;     // bit 7
        logic       master;     // bit 6
        logic       miso_off;   // bit 5
        logic       ss_err_en;  // bit 4
        logic       get_more;   // bit 3
        logic       send_zero;  // bit 2
        init_mode_e imode;      // bits 1:0
    } ctrl_t;

    localparam int          REG_W  = 8;
    localparam int          ADDR_W = 3;
    localparam logic [2:0]  A_CTRL = 3'd0;
    localparam logic [2:0]  A_STAT = 3'd1;
    localparam logic [2:0]  A_TX   = 3'd2;
    localparam logic [2:0]  A_RX   = 3'd3;
    localparam logic [2:0]  A_DIV  = 3'd4;

    // Status bit positions that software clears by writing 1
    localparam int ST_OVF  = 2;
    localparam int ST_MODF = 3;

endpackage

// File: rtl/spi_pin_sync.sv
// Multi-flop synchronizer for asynchronous SPI pin inputs.
// Assumes STAGES >= 1; RST_VAL gives the idle level of each pin.
module spi_pin_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            // single flop stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= RST_VAL;
                else        pipe_q <= d;
            end
        end else begin : g_multi
            // shift pin values through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
                else        pipe_q <= {pipe_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_sclk_gen.sv
// Master SCLK generator: each half period lasts DIV+1 clock cycles while run
// is high; SCLK rests low. Emits single-cycle rise/fall strobes aligned with
// the register edge at which sclk changes.
module spi_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             tick;

    assign tick = run && (cnt_q == div);
    assign rise = tick && !sclk_q;
    assign fall = tick && sclk_q;
    assign sclk = sclk_q;

    // half-period counter and SCLK toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R2: with the generator stopped, SCLK must sit low
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk_q);

endmodule

// File: rtl/spi_shift_reg.sv
// Mode-0 shift register: samples serial input on rise, shifts on fall,
// MSB first. done pulses with the last fall; word is valid in that cycle.
// load has priority over edges so a follow-on word can start at done.
module spi_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         abort,
    input  logic         rise,
    input  logic         fall,
    input  logic         sdi,
    output logic         sdo,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic          bit_q;
    logic [CW-1:0] cnt_q;

    assign done = fall && (cnt_q == CW'(W - 1));
    assign word = {sh_q[W-2:0], bit_q};
    assign sdo  = sh_q[W-1];

    // shift data path and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
            cnt_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            cnt_q <= '0;
        end else begin
            if (rise) bit_q <= sdi;
            if (fall) begin
                sh_q  <= word;
                cnt_q <= done ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // R2: the first bit on the line is the MSB of the loaded word
    p_load_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !abort) |=> (sdo == $past(load_val[W-1])));

endmodule

// File: rtl/spi_xfer_ctrl.sv
// SPI transfer controller top: register bank, single-word tx/rx buffers,
// start logic, mode-fault handling and pin muxing between master and slave.
// Assumes DATA_W >= 8 so the control and status bytes fit on the bus.
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              ss_out_n,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              ss_in_n,
    output logic              irq,
    output logic              dma_rx_full,
    output logic              dma_tx_empty
);
    localparam int SYNC_W = 3;

    // ---------------- state ----------------
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] txbuf_q, last_q, rxbuf_q;
    logic              tx_full_q, rx_full_q;
    logic              ovf_q, modf_q;
    logic              busy_q, role_q;       // role_q: 1 = master transfer
    logic              req_q;
    logic              ss_p_q, sclk_p_q;

    // ---------------- pin synchronizers ----------------
    logic [SYNC_W-1:0] sync_q;
    logic              ss_s, sclk_s, mosi_s;

    spi_pin_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_in_n, sclk_i, mosi_i}),
        .q     (sync_q)
    );
    assign {ss_s, sclk_s, mosi_s} = sync_q;

    // previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_p_q   <= 1'b1;
            sclk_p_q <= 1'b0;
        end else begin
            ss_p_q   <= ss_s;
            sclk_p_q <= sclk_s;
        end
    end

    // ---------------- decode ----------------
    logic wr_ctrl, wr_stat, wr_tx, wr_div, rd_rx;
    logic mode_ok, is_master, is_slave, ss_act, slave_act, mf_evt;
    logic trig, start_m, slave_begin, slave_next, load, abort, capture;
    logic [DATA_W-1:0] load_val, word;
    logic done, sdo;
    logic rise_m, fall_m, rise_x, fall_x, sdi_x, sclk_run;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_tx   = bus_wr && (bus_addr == A_TX);
    assign wr_div  = bus_wr && (bus_addr == A_DIV);
    assign rd_rx   = bus_rd && (bus_addr == A_RX);

    assign mode_ok   = (ctrl_q.imode != IM_RSVD);
    assign is_master = ctrl_q.enable && ctrl_q.master;
    assign is_slave  = ctrl_q.enable && !ctrl_q.master;
    assign ss_act    = !ss_s;
    assign slave_act = is_slave && ss_act && mode_ok;
    assign mf_evt    = is_master && ctrl_q.ss_err_en && ss_act;

    assign trig = ((ctrl_q.imode == IM_RX_READ) && rd_rx) ||
                  (((ctrl_q.imode == IM_TX_WRITE) || (ctrl_q.imode == IM_DMA)) && wr_tx);

    assign start_m     = is_master && req_q && !busy_q && !mf_evt && mode_ok;
    assign slave_begin = slave_act && ss_p_q && !busy_q;
    assign slave_next  = slave_act && busy_q && !role_q && done;
    assign load        = start_m || slave_begin || slave_next;
    assign load_val    = tx_full_q ? txbuf_q : (ctrl_q.send_zero ? '0 : last_q);

    assign abort = mf_evt ||
                   (busy_q && !role_q && !slave_act) ||
                   (busy_q &&  role_q && !is_master);
    assign capture = busy_q && done && !abort;

    // ---------------- datapath instances ----------------
    assign sclk_run = busy_q && role_q;

    spi_sclk_gen #(
        .DIV_W (DIV_W)
    ) i_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sclk_run),
        .div   (div_q),
        .sclk  (sclk_o),
        .rise  (rise_m),
        .fall  (fall_m)
    );

    assign rise_x = busy_q && (role_q ? rise_m : (slave_act && sclk_s && !sclk_p_q));
    assign fall_x = busy_q && (role_q ? fall_m : (slave_act && !sclk_s && sclk_p_q));
    assign sdi_x  = role_q ? miso_i : mosi_s;

    spi_shift_reg #(
        .W (DATA_W)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .abort    (abort),
        .rise     (rise_x),
        .fall     (fall_x),
        .sdi      (sdi_x),
        .sdo      (sdo),
        .done     (done),
        .word     (word)
    );

    // ---------------- registers ----------------
    // control byte, divider and mode-fault status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
            modf_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[REG_W-1:0]);
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            if (wr_stat && bus_wdata[ST_MODF]) modf_q <= 1'b0;
            if (mf_evt) begin
                ctrl_q.master <= 1'b0;
                modf_q        <= 1'b1;
            end
        end
    end

    // transmit holding buffer and last-sent word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf_q   <= '0;
            last_q    <= '0;
            tx_full_q <= 1'b0;
        end else begin
            if (load && tx_full_q) begin
                tx_full_q <= 1'b0;
                last_q    <= txbuf_q;
            end
            if (wr_tx) begin
                txbuf_q   <= bus_wdata;
                tx_full_q <= 1'b1;
            end
        end
    end

    // receive holding buffer with overflow policy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf_q   <= '0;
            rx_full_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (rd_rx) rx_full_q <= 1'b0;
            if (wr_stat && bus_wdata[ST_OVF]) ovf_q <= 1'b0;
            if (capture) begin
                if (rx_full_q && !rd_rx) begin
                    ovf_q <= 1'b1;
                    if (ctrl_q.get_more) rxbuf_q <= word;
                end else begin
                    rxbuf_q   <= word;
                    rx_full_q <= 1'b1;
                end
            end
        end
    end

    // pending master start request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            if (start_m || mf_evt || !mode_ok || !is_master) req_q <= 1'b0;
            if (trig && is_master && mode_ok) req_q <= 1'b1;
        end
    end

    // transfer-in-progress flag and its role
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            role_q <= 1'b0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (load) begin
            busy_q <= 1'b1;
            role_q <= start_m;
        end else if (done && busy_q && role_q) begin
            busy_q <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    logic [REG_W-1:0] status;
    assign status = {ss_s, 2'b00, busy_q, modf_q, ovf_q, !tx_full_q, rx_full_q};

    // register read multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_STAT:  bus_rdata = DATA_W'(status);
            A_RX:    bus_rdata = rxbuf_q;
            A_DIV:   bus_rdata = DATA_W'(div_q);
            default: bus_rdata = '0;
        endcase
    end

    assign ss_out_n = !(busy_q && role_q);
    assign mosi_o   = busy_q && role_q && sdo;
    assign miso_o   = sdo;
    assign miso_oe  = slave_act && busy_q && !role_q && !ctrl_q.miso_off;

    assign irq = ctrl_q.enable &&
                 (((ctrl_q.imode == IM_RX_READ)  &&  rx_full_q) ||
                  ((ctrl_q.imode == IM_TX_WRITE) && !tx_full_q));
    assign dma_rx_full  = ctrl_q.enable && (ctrl_q.imode == IM_DMA) &&  rx_full_q;
    assign dma_tx_empty = ctrl_q.enable && (ctrl_q.imode == IM_DMA) && !tx_full_q;

    // ---------------- assertions ----------------
    // R5: a word landing on a full buffer always marks overflow
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && rx_full_q && !rd_rx) |=> ovf_q);

    // R5: discard policy keeps the buffered word
    p_discard_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && rx_full_q && !rd_rx && !ctrl_q.get_more) |=> $stable(rxbuf_q));

    // R6: a mode fault drops master, flags it and releases the select line
    p_modf_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mf_evt |=> (!ctrl_q.master && modf_q && ss_out_n));

    // R7: with error detection off the select input cannot clear master
    p_ss_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !ctrl_q.ss_err_en && ss_act && !wr_ctrl) |=> ctrl_q.master);

    // R10: DMA mode never raises the interrupt
    p_dma_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.imode == IM_DMA) |-> !irq);

    // R11: reserved start mode never leaves idle
    p_rsvd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q.imode == IM_RSVD) && !busy_q) |=> !busy_q);

endmodule

// File: tb/test_spi_xfer_ctrl.sv
`timescale 1ns/1ps
module test_spi_xfer_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk_o, mosi_o, ss_out_n, miso_o, miso_oe;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, ss_in_n = 1'b1;
    logic       irq, dma_rx_full, dma_tx_empty;
    logic       loop_en = 1'b1;
    logic       miso_i;
    int         n_tests = 0, n_fail = 0;
    bit         finished = 1'b0;

    assign miso_i = loop_en ? mosi_o : 1'b0;

    always #2 clk = !clk;   // 250 MHz

    spi_xfer_ctrl i_spi_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_out_n(ss_out_n), .miso_i(miso_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .sclk_i(sclk_i), .mosi_i(mosi_i),
        .ss_in_n(ss_in_n), .irq(irq), .dma_rx_full(dma_rx_full),
        .dma_tx_empty(dma_tx_empty)
    );

    // expected frame length in clocks for a divider value
    function automatic int exp_len(input int div);
        return 16 * (div + 1);
    endfunction

    // expected word when the transmit buffer is empty
    function automatic logic [7:0] exp_underrun(input bit sendz, input logic [7:0] last);
        return sendz ? 8'h00 : last;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // wait for a master frame and count select-low cycles
    task automatic frame(output int n);
        int guard = 0;
        n = 0;
        while (ss_out_n && guard < 200) begin @(negedge clk); guard++; end
        while (!ss_out_n && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd, w, last, s_word, m_word;
        int         n, div;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(4);

        // R1: reset state
        bus_read(3'd0, rd); chk(rd == 8'h00, "R1 ctrl reset", rd, 8'h00);
        bus_read(3'd1, rd); chk(rd == 8'h82, "R1 status reset", rd, 8'h82);
        chk(ss_out_n == 1'b1 && irq == 1'b0 && miso_oe == 1'b0, "R1 pins idle",
            {ss_out_n, irq, miso_oe}, 3'b100);

        // R2: transmit-write start, random words and dividers, loopback
        bus_write(3'd0, 8'hC1);
        chk(irq == 1'b1, "R2 irq tx empty", irq, 1);
        last = 8'h00;
        for (int k = 0; k < 6; k++) begin
            div = (k == 0) ? 0 : int'($urandom_range(3, 0));
            w   = 8'($urandom);
            if (k == 1) w = 8'h80;
            if (k == 2) w = 8'h01;
            bus_write(3'd4, 8'(div));
            bus_write(3'd2, w);
            frame(n);
            chk(n == exp_len(div), "R2 frame length", n, exp_len(div));
            bus_read(3'd3, rd);
            chk(rd == w, "R2 loopback word", rd, w);
            last = w;
        end
        bus_write(3'd4, 8'd0);

        // R3: receive-read start, interrupt on rx full
        bus_write(3'd0, 8'hC0);
        chk(irq == 1'b0, "R3 irq rx empty", irq, 0);
        bus_read(3'd3, rd);
        frame(n);
        chk(n == exp_len(0), "R3 read starts frame", n, exp_len(0));
        chk(irq == 1'b1, "R3 irq rx full", irq, 1);

        // R4: underrun repeats last word
        bus_write(3'd0, 8'hC1);
        bus_read(3'd3, rd);
        chk(rd == exp_underrun(1'b0, last), "R4 repeat last", rd, exp_underrun(1'b0, last));
        // R4: underrun sends zeros
        bus_write(3'd0, 8'hC4);
        bus_read(3'd3, rd);
        frame(n);
        bus_write(3'd0, 8'hC5);
        bus_read(3'd3, rd);
        chk(rd == exp_underrun(1'b1, last), "R4 send zeros", rd, 8'h00);

        // R5: discard policy
        bus_write(3'd0, 8'hC1);
        bus_write(3'd2, 8'hA5); frame(n);
        bus_write(3'd2, 8'h3C); frame(n);
        bus_read(3'd1, rd);
        chk(rd[2] == 1'b1, "R5 overflow flag discard", rd, 8'h04);
        bus_read(3'd3, rd);
        chk(rd == 8'hA5, "R5 discard keeps old", rd, 8'hA5);
        bus_write(3'd1, 8'h04);
        bus_read(3'd1, rd);
        chk(rd[2] == 1'b0, "R5 overflow cleared", rd, 0);
        // R5: overwrite policy
        bus_write(3'd0, 8'hC9);
        bus_write(3'd2, 8'h5A); frame(n);
        bus_write(3'd2, 8'hC3); frame(n);
        bus_read(3'd1, rd);
        chk(rd[2] == 1'b1, "R5 overflow flag overwrite", rd, 8'h04);
        bus_read(3'd3, rd);
        chk(rd == 8'hC3, "R5 overwrite new", rd, 8'hC3);
        bus_write(3'd1, 8'h04);

        // R6: mode fault aborts a running transfer
        bus_write(3'd0, 8'hD1);
        bus_write(3'd4, 8'd3);
        bus_write(3'd2, 8'h77);
        idle(10);
        chk(ss_out_n == 1'b0, "R6 frame running", ss_out_n, 0);
        ss_in_n = 1'b0;
        idle(5);
        chk(ss_out_n == 1'b1, "R6 select released", ss_out_n, 1);
        bus_read(3'd0, rd);
        chk(rd == 8'h91, "R6 master dropped", rd, 8'h91);
        bus_read(3'd1, rd);
        chk(rd[3] == 1'b1 && rd[4] == 1'b0, "R6 fault flag", rd, 8'h08);
        ss_in_n = 1'b1;
        idle(4);
        bus_write(3'd1, 8'h08);
        bus_read(3'd1, rd);
        chk(rd[3] == 1'b0, "R6 fault cleared", rd, 0);

        // R7: select input ignored without error detection
        bus_write(3'd4, 8'd0);
        bus_write(3'd0, 8'hC1);
        ss_in_n = 1'b0;
        bus_write(3'd2, 8'h6E);
        frame(n);
        chk(n == exp_len(0), "R7 frame completes", n, exp_len(0));
        bus_read(3'd3, rd);
        chk(rd == 8'h6E, "R7 word received", rd, 8'h6E);
        bus_read(3'd0, rd);
        chk(rd == 8'hC1, "R7 master kept", rd, 8'hC1);
        ss_in_n = 1'b1;
        idle(4);

        // R11: reserved mode never starts
        bus_write(3'd0, 8'hC3);
        bus_write(3'd2, 8'h99);
        n = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (!ss_out_n) n++;
        end
        chk(n == 0, "R11 no frame", n, 0);
        bus_read(3'd1, rd);
        chk(rd[4] == 1'b0 && irq == 1'b0, "R11 idle", rd, 8'h80);

        // R10: DMA mode
        bus_write(3'd0, 8'hC2);
        chk(dma_tx_empty == 1'b0 && irq == 1'b0, "R10 tx held", dma_tx_empty, 0);
        bus_write(3'd2, 8'h4B);
        frame(n);
        chk(dma_rx_full == 1'b1 && irq == 1'b0, "R10 rx full line", dma_rx_full, 1);
        bus_read(3'd3, rd);
        chk(rd == 8'h4B, "R10 word", rd, 8'h4B);
        chk(dma_rx_full == 1'b0 && dma_tx_empty == 1'b1, "R10 lines after read",
            {dma_rx_full, dma_tx_empty}, 2'b01);

        // R8: slave transfer
        loop_en = 1'b0;
        s_word = 8'($urandom);
        m_word = 8'($urandom);
        bus_write(3'd0, 8'h81);
        bus_write(3'd2, s_word);
        ss_in_n = 1'b0;
        idle(6);
        chk(miso_oe == 1'b1, "R9 slave drives", miso_oe, 1);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = m_word[i];
            idle(6);
            sclk_i = 1'b1;
            idle(6);
            chk(miso_o == s_word[i], "R8 slave bit out", miso_o, s_word[i]);
            sclk_i = 1'b0;
            idle(6);
        end
        bus_read(3'd1, rd);
        chk(rd[0] == 1'b1 && rd[7] == 1'b0, "R8 status rx full, select low", rd, 8'h01);
        ss_in_n = 1'b1;
        idle(5);
        bus_read(3'd3, rd);
        chk(rd == m_word, "R8 slave word in", rd, m_word);
        bus_read(3'd1, rd);
        chk(rd[7] == 1'b1, "R8 select level high", rd, 8'h80);

        // R9: MISO disabled while selected
        bus_write(3'd0, 8'hA1);
        ss_in_n = 1'b0;
        idle(6);
        chk(miso_oe == 1'b0, "R9 driver off", miso_oe, 0);
        ss_in_n = 1'b1;
        idle(4);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule